// File: doc/BRIEF.md
# Flash Query Mode Controller

This block is the command side of a parallel NOR flash that can be interrogated for its parameter table. It watches host write cycles for command codes and keeps track of the read mode: array, identifier (autoselect), or query. Reads return data that depends on that mode. Array reads return a fixed placeholder, because no array storage is modelled. Autoselect reads return manufacturer and device codes. Query reads return entries of a fixed parameter table.

The block serves a word-wide bus and a byte-wide bus, chosen by a select input. In byte mode every address is the word address doubled. The block remembers which mode query was entered from, so the reset command returns there. Program, erase, status polling and electrical timing are outside the block.

The host bus is synchronous. A write strobe, a read strobe, an address, write data and registered read data are sampled on the rising clock edge.

Top module: `flash_query_ctrl`

## Requirements
- R1: When rstN is low, the block returns to array mode and rdData is cleared to 0000h.
- R2: A write whose low data byte is 98h enters query mode. In word mode it must go to address 55h, and in byte mode to byte address AAh. It is accepted from array mode and from autoselect mode.
- R3: A write of F0h to any address is the reset command. In query mode it returns to the mode query was entered from. In autoselect mode it returns to array mode. In array mode it changes nothing.
- R4: Three consecutive writes in array mode enter autoselect mode: AAh to word address 555h, then 55h to 2AAh, then 90h to 555h. Byte mode uses the doubled addresses. Any other write in between aborts the sequence. In autoselect mode, word offset 0 reads 001Ch, offset 1 reads 22C4h, and every other offset reads 0000h.
- R5: In query mode, the word offsets read as follows:
  - 10h to 15h read 0051h, 0052h, 0059h, 0002h, 0000h, 0040h.
  - 16h to 1Ah read 0000h.
  - 1Bh to 26h read 0027h, 0036h, 0000h, 0000h, 0004h, 0000h, 000Ah, 0000h, 0005h, 0000h, 0004h, 0000h.
  - Every other offset reads 0000h.
- R6: In word mode, a query read with any address bit from bit 7 upward set returns 0000h.
- R7: In byte mode, byte address 2n reads the low byte of word offset n. Odd byte addresses return 0000h, and any byte address bit from bit 8 upward set returns 0000h in query mode. In all modes, rdData[15:8] is 00h in byte mode.
- R8: In array mode, reads return A5C3h in word mode and 00C3h in byte mode.
- R9: A write that matches no accepted command leaves the mode unchanged. Examples are 98h to the wrong address, and 90h while in query mode.
- R10: rdData updates on the clock edge where rdEn is high, and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe for one bus write cycle |
| rdEn | input | 1 | Read strobe; loads rdData |
| byteMode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| addr | input | ADDR_W | Bus address (byte address in byte mode) |
| wrData | input | 16 | Write data; the low byte carries the command |
| rdData | output | 16 | Registered read data |

## Verification
The assertions assume that wrEn and rdEn are never high in the same cycle. They also assume that byteMode and addr are steady for the whole cycle in which a strobe is high. The assertions on mode transitions further rely on wrData being a defined value whenever wrEn is high.

The stimulus keeps within these assumptions. Every input is driven on the falling edge, and each access is a single strobed cycle followed by an idle cycle. The bus width is changed only while both strobes are low.

// File: rtl/flash_query_pkg.sv
package flash_query_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_AUTO  = 2'd1,
    MODE_QUERY = 2'd2
  } modeT;

  // one-hot read source strobes from control to datapath
  typedef struct packed {
    logic selArray;
    logic selAuto;
    logic selQuery;
  } readSelT;

  localparam int CMD_AW = 11;

  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_UNLOCKA = 8'hAA;
  localparam logic [7:0] CMD_UNLOCKB = 8'h55;
  localparam logic [7:0] CMD_AUTOSEL = 8'h90;

  localparam logic [CMD_AW-1:0] ADR_QUERY   = 11'h055;
  localparam logic [CMD_AW-1:0] ADR_UNLOCKA = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_UNLOCKB = 11'h2AA;

endpackage

// File: rtl/flash_query_ctl.sv
module flash_query_ctl
  import flash_query_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        cmdByte,
  input  logic [CMD_AW-1:0] cmdAddr,
  output modeT              curMode,
  output modeT              retMode,
  output readSelT           readSel
);

  logic [1:0] unlockStep;
  logic [1:0] stepNext;
  modeT       modeNext;
  modeT       retNext;

  logic isQueryCmd;
  logic isResetCmd;
  logic isUnlockA;
  logic isUnlockB;
  logic isAutoCmd;

  assign isQueryCmd = (cmdByte == CMD_QUERY)   && (cmdAddr == ADR_QUERY);
  assign isResetCmd = (cmdByte == CMD_RESET);
  assign isUnlockA  = (cmdByte == CMD_UNLOCKA) && (cmdAddr == ADR_UNLOCKA);
  assign isUnlockB  = (cmdByte == CMD_UNLOCKB) && (cmdAddr == ADR_UNLOCKB);
  assign isAutoCmd  = (cmdByte == CMD_AUTOSEL) && (cmdAddr == ADR_UNLOCKA);

  always_comb begin
    modeNext = curMode;
    retNext  = retMode;
    stepNext = unlockStep;
    if (wrEn) begin
      stepNext = 2'd0;
      case (curMode)
        MODE_ARRAY: begin
          if (isQueryCmd) begin
            modeNext = MODE_QUERY;
            retNext  = MODE_ARRAY;
          end else if (unlockStep == 2'd1 && isUnlockB) begin
            stepNext = 2'd2;
          end else if (unlockStep == 2'd2 && isAutoCmd) begin
            modeNext = MODE_AUTO;
          end else if (isUnlockA) begin
            stepNext = 2'd1;
          end
        end
        MODE_AUTO: begin
          if (isQueryCmd) begin
            modeNext = MODE_QUERY;
            retNext  = MODE_AUTO;
          end else if (isResetCmd) begin
            modeNext = MODE_ARRAY;
          end
        end
        MODE_QUERY: begin
          if (isResetCmd) modeNext = retMode;
        end
        default: modeNext = MODE_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode    <= MODE_ARRAY;
      retMode    <= MODE_ARRAY;
      unlockStep <= 2'd0;
    end else begin
      curMode    <= modeNext;
      retMode    <= retNext;
      unlockStep <= stepNext;
    end
  end

  assign readSel.selArray = (curMode == MODE_ARRAY);
  assign readSel.selAuto  = (curMode == MODE_AUTO);
  assign readSel.selQuery = (curMode == MODE_QUERY);

endmodule

// File: rtl/flash_query_dp.sv
module flash_query_dp
  import flash_query_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter logic [15:0] ARRAY_FILL = 16'hA5C3,
  parameter logic [15:0] MFR_CODE   = 16'h001C,
  parameter logic [15:0] DEV_CODE   = 16'h22C4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] addr,
  input  readSelT           readSel,
  output logic [CMD_AW-1:0] cmdAddr,
  output logic [15:0]       rdData
);

  localparam int TBL_AW = 7;

  logic [ADDR_W-1:0] wordAddr;
  logic              oddByte;
  logic              upperClear;
  logic [15:0]       queryWord;
  logic [15:0]       autoWord;
  logic [15:0]       modeWord;
  logic [15:0]       busWord;

  function automatic logic [15:0] queryTable(input logic [TBL_AW-1:0] off);
    case (off)
      7'h10: queryTable = 16'h0051;
      7'h11: queryTable = 16'h0052;
      7'h12: queryTable = 16'h0059;
      7'h13: queryTable = 16'h0002;
      7'h15: queryTable = 16'h0040;
      7'h1B: queryTable = 16'h0027;
      7'h1C: queryTable = 16'h0036;
      7'h1F: queryTable = 16'h0004;
      7'h21: queryTable = 16'h000A;
      7'h23: queryTable = 16'h0005;
      7'h25: queryTable = 16'h0004;
      default: queryTable = 16'h0000;
    endcase
  endfunction

  // byte bus: drop address bit 0, remember whether it was set
  assign wordAddr   = byteMode ? {1'b0, addr[ADDR_W-1:1]} : addr;
  assign oddByte    = byteMode & addr[0];
  assign cmdAddr    = wordAddr[CMD_AW-1:0];
  assign upperClear = (wordAddr[ADDR_W-1:TBL_AW] == '0);

  assign queryWord = (upperClear && !oddByte) ? queryTable(wordAddr[TBL_AW-1:0]) : 16'h0000;
  assign autoWord  = (wordAddr[ADDR_W-1:1] != '0) ? 16'h0000 :
                     (wordAddr[0] ? DEV_CODE : MFR_CODE);

  always_comb begin
    modeWord = 16'h0000;
    if (readSel.selArray) modeWord = ARRAY_FILL;
    if (readSel.selAuto)  modeWord = autoWord;
    if (readSel.selQuery) modeWord = queryWord;
  end

  assign busWord = byteMode ? {8'h00, modeWord[7:0]} : modeWord;

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= 16'h0000;
    else if (rdEn) rdData <= busWord;
  end

endmodule

// File: rtl/flash_query_ctrl.sv
module flash_query_ctrl
  import flash_query_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter logic [15:0] ARRAY_FILL = 16'hA5C3,
  parameter logic [15:0] MFR_CODE   = 16'h001C,
  parameter logic [15:0] DEV_CODE   = 16'h22C4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData
);

  modeT              curMode;
  modeT              retMode;
  readSelT           readSel;
  logic [CMD_AW-1:0] cmdAddr;
  logic              unusedDataHi;

  // commands live in the low data byte only
  assign unusedDataHi = ^wrData[15:8];

  flash_query_ctl i_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .cmdByte (wrData[7:0]),
    .cmdAddr (cmdAddr),
    .curMode (curMode),
    .retMode (retMode),
    .readSel (readSel)
  );

  flash_query_dp #(
    .ADDR_W     (ADDR_W),
    .ARRAY_FILL (ARRAY_FILL),
    .MFR_CODE   (MFR_CODE),
    .DEV_CODE   (DEV_CODE)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rdEn     (rdEn),
    .byteMode (byteMode),
    .addr     (addr),
    .readSel  (readSel),
    .cmdAddr  (cmdAddr),
    .rdData   (rdData)
  );

endmodule

// File: rtl/flash_query_chk.sv
module flash_query_chk
  import flash_query_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              byteMode,
  input logic [15:0]       wrData,
  input logic [15:0]       rdData,
  input logic [CMD_AW-1:0] cmdAddr,
  input modeT              curMode,
  input modeT              retMode
);

  assert_reset_array_R1: assert property (@(posedge clk)
    !rstN |=> (curMode == MODE_ARRAY && rdData == 16'h0000));

  assert_query_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[7:0] == CMD_QUERY && cmdAddr == ADR_QUERY && curMode != MODE_QUERY)
    |=> curMode == MODE_QUERY);

  assert_query_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[7:0] == CMD_RESET && curMode == MODE_QUERY)
    |=> curMode == $past(retMode));

  assert_array_reset_noop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[7:0] == CMD_RESET && curMode == MODE_ARRAY)
    |=> curMode == MODE_ARRAY);

  assert_return_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    retMode != MODE_QUERY);

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && byteMode) |=> rdData[15:8] == 8'h00);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(curMode));

  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind flash_query_ctrl flash_query_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .byteMode (byteMode),
  .wrData   (wrData),
  .rdData   (rdData),
  .cmdAddr  (cmdAddr),
  .curMode  (curMode),
  .retMode  (retMode)
);

// File: tb/test_flash_query_ctrl.sv
`timescale 1ns/1ps
module test_flash_query_ctrl;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic              byteMode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wrData = '0;
  logic [15:0]       rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flash_query_ctrl #(.ADDR_W(ADDR_W)) i_flash_query_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .byteMode(byteMode),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  typedef struct packed {
    logic        isRd;
    logic        bm;
    logic [19:0] a;
    logic [15:0] v;   // write data, or expected read data
    logic [3:0]  req;
  } vecT;

  localparam int NVEC = 38;
  localparam vecT VECS [NVEC] = '{
    '{1'b1, 1'b0, 20'h00000, 16'hA5C3, 4'd8},  // R8 array word
    '{1'b1, 1'b1, 20'h00001, 16'h00C3, 4'd8},  // R8 array byte
    '{1'b0, 1'b0, 20'h00055, 16'h0098, 4'd2},  // R2 enter from array
    '{1'b1, 1'b0, 20'h00010, 16'h0051, 4'd5},  // R5
    '{1'b1, 1'b0, 20'h00011, 16'h0052, 4'd5},
    '{1'b1, 1'b0, 20'h00012, 16'h0059, 4'd5},
    '{1'b1, 1'b0, 20'h00013, 16'h0002, 4'd5},
    '{1'b1, 1'b0, 20'h00015, 16'h0040, 4'd5},
    '{1'b1, 1'b0, 20'h0001B, 16'h0027, 4'd5},
    '{1'b1, 1'b0, 20'h0001C, 16'h0036, 4'd5},
    '{1'b1, 1'b0, 20'h0001F, 16'h0004, 4'd5},
    '{1'b1, 1'b0, 20'h00021, 16'h000A, 4'd5},
    '{1'b1, 1'b0, 20'h00023, 16'h0005, 4'd5},
    '{1'b1, 1'b0, 20'h00025, 16'h0004, 4'd5},
    '{1'b1, 1'b0, 20'h00026, 16'h0000, 4'd5},
    '{1'b1, 1'b0, 20'h0000F, 16'h0000, 4'd5},
    '{1'b1, 1'b0, 20'h00090, 16'h0000, 4'd6},  // R6 bit 7 set
    '{1'b1, 1'b0, 20'h00110, 16'h0000, 4'd6},  // R6 bit 8 set
    '{1'b1, 1'b1, 20'h00020, 16'h0051, 4'd7},  // R7 doubled address
    '{1'b1, 1'b1, 20'h00036, 16'h0027, 4'd7},
    '{1'b1, 1'b1, 20'h00021, 16'h0000, 4'd7},  // R7 odd byte
    '{1'b1, 1'b1, 20'h00042, 16'h000A, 4'd7},
    '{1'b1, 1'b1, 20'h00120, 16'h0000, 4'd7},  // R7 upper bit
    '{1'b0, 1'b0, 20'h00123, 16'h00F0, 4'd3},  // R3 back to array
    '{1'b1, 1'b0, 20'h00010, 16'hA5C3, 4'd3},
    '{1'b0, 1'b0, 20'h00555, 16'h00AA, 4'd4},  // R4 unlock
    '{1'b0, 1'b0, 20'h002AA, 16'h0055, 4'd4},
    '{1'b0, 1'b0, 20'h00555, 16'h0090, 4'd4},
    '{1'b1, 1'b0, 20'h00000, 16'h001C, 4'd4},
    '{1'b1, 1'b0, 20'h00001, 16'h22C4, 4'd4},
    '{1'b1, 1'b0, 20'h00002, 16'h0000, 4'd4},
    '{1'b1, 1'b1, 20'h00002, 16'h00C4, 4'd4},
    '{1'b0, 1'b1, 20'h000AA, 16'h0098, 4'd2},  // R2 enter from autoselect, byte bus
    '{1'b1, 1'b1, 20'h00024, 16'h0059, 4'd2},
    '{1'b0, 1'b0, 20'h00000, 16'h00F0, 4'd3},  // R3 back to autoselect
    '{1'b1, 1'b0, 20'h00001, 16'h22C4, 4'd3},
    '{1'b0, 1'b0, 20'h00000, 16'h00F0, 4'd3},  // R3 autoselect to array
    '{1'b1, 1'b0, 20'h00001, 16'hA5C3, 4'd3}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%04h expected=%04h", tag, got, exp);
    end
  endtask

  task automatic doWrite(input logic bm, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    byteMode = bm; addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic bm, input logic [19:0] a, input logic [15:0] exp,
                        input string tag);
    @(negedge clk);
    byteMode = bm; addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", rdData, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRd)
        doRead(VECS[i].bm, VECS[i].a, VECS[i].v, $sformatf("R%0d vector %0d", VECS[i].req, i));
      else
        doWrite(VECS[i].bm, VECS[i].a, VECS[i].v);
    end

    // R3: reset command in array mode has no effect
    doWrite(1'b0, 20'h00055, 16'h00F0);
    doRead(1'b0, 20'h00010, 16'hA5C3, "R3 reset in array ignored");

    // R4: interrupted unlock sequence is abandoned
    doWrite(1'b0, 20'h00555, 16'h00AA);
    doWrite(1'b0, 20'h00000, 16'h0011);
    doWrite(1'b0, 20'h00555, 16'h0090);
    doRead(1'b0, 20'h00000, 16'hA5C3, "R4 aborted unlock");

    // R9: query command at wrong address
    doWrite(1'b0, 20'h00056, 16'h0098);
    doRead(1'b0, 20'h00010, 16'hA5C3, "R9 query cmd wrong address");

    // R4: unlock on the byte bus with doubled addresses
    doWrite(1'b1, 20'h00AAA, 16'h00AA);
    doWrite(1'b1, 20'h00554, 16'h0055);
    doWrite(1'b1, 20'h00AAA, 16'h0090);
    doRead(1'b1, 20'h00000, 16'h001C, "R4 byte-bus unlock");

    // R9: stray autoselect command inside autoselect
    doWrite(1'b0, 20'h00555, 16'h0090);
    doRead(1'b0, 20'h00001, 16'h22C4, "R9 stray write in autoselect");

    // R9: autoselect command while in query mode
    doWrite(1'b0, 20'h00055, 16'h0098);
    doWrite(1'b0, 20'h00555, 16'h0090);
    doRead(1'b0, 20'h00010, 16'h0051, "R9 stray write in query");

    // R10: rdData holds while rdEn is low
    @(negedge clk);
    addr = 20'h00012;
    @(negedge clk);
    @(negedge clk);
    check("R10 read data held", rdData, 16'h0051);

    // R1: reset from query mode
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 rdData cleared", rdData, 16'h0000);
    doRead(1'b0, 20'h00010, 16'hA5C3, "R1 array after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule